// File: doc/BRIEF.md
# UART Modem Status Register

This block holds the modem-status register logic of a UART. Four active-low modem control pins (carrier detect, ring indicator, data set ready, clear to send) pass through synchronizers. The upper nibble of a read-only status byte shows their present state. The lower nibble holds four sticky change flags. A host read of the register returns the byte and clears the change flags. A modem-status interrupt is raised while any change flag is set. In internal loopback the status bits are taken from the UART's own modem-control outputs instead of the pins.

A host write to the same address does not touch the status register. It stores the data into a separate feature-control byte, which this block keeps as plain storage and drives out to its neighbours.

Each change flag is a small two-state machine with two states:
- `FLAG_IDLE`: the flag reads 0.
- `FLAG_PENDING`: the flag reads 1.

It has three transitions:
- `SET`: a qualifying edge, taken from either state, leads to `FLAG_PENDING`.
- `CLEAR`: a read with no edge in the same cycle leads from `FLAG_PENDING` to `FLAG_IDLE`.
- `HOLD`: in every other case the flag stays in its state.

Top module: `uart_modem_status`

## Requirements
- R1: With `loop_en` low, status bits 7, 6, 5 and 4 read as the inverse of `cd_n`, `ri_n`, `dsr_n` and `cts_n` respectively. Each pin passes through a two-flop synchronizer, so a pin change shows on `rd_data` after the second rising clock edge.
- R2: With `loop_en` high, the status bits come from `mdm_ctl` combinationally:
  - bit 7 = `mdm_ctl[3]`
  - bit 6 = `mdm_ctl[2]`
  - bit 5 = `mdm_ctl[0]`
  - bit 4 = `mdm_ctl[1]`
- R3: Change flags at bit 3 (CD), bit 1 (DSR) and bit 0 (CTS) set when their status bit changes value in either direction. A flag reads 1 from the clock edge after the status bit changes.
- R4: Change flag bit 2 (RI) sets only when status bit 6 goes from 1 to 0. In normal mode that is the RI pin rising. A 0-to-1 change of status bit 6 leaves the flag unchanged.
- R5: A read (`rd_stb` and `reg_sel` both high for one cycle) returns the flags as they stand in that cycle. Flags with no qualifying edge in that cycle read 0 from the next edge.
- R6: A qualifying edge in the same cycle as a read leaves that flag set.
- R7: `msi_irq` is high exactly when any of `rd_data[3:0]` is 1.
- R8: After reset all change flags are 0 and `feat_ctl` is 0x00.
- R9: A write (`wr_stb` and `reg_sel` high) loads `wr_data` into `feat_ctl` at the next edge. A write never alters `rd_data`.
- R10: `rd_stb` or `wr_stb` without `reg_sel` has no effect on the flags or on `feat_ctl`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_n | input | 1 | Carrier detect pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| cts_n | input | 1 | Clear to send pin, active low |
| loop_en | input | 1 | Internal loopback select |
| mdm_ctl | input | 4 | Modem-control outputs: [3] OP2, [2] OP1, [1] RTS, [0] DTR |
| reg_sel | input | 1 | Address match for this register |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data for the feature-control byte |
| rd_data | output | 8 | Status byte: [7:4] line state, [3:0] change flags |
| feat_ctl | output | 8 | Stored feature-control byte |
| msi_irq | output | 1 | Modem-status interrupt |

## Verification
The hardest situation to reach is a qualifying edge that lands in exactly the same cycle as a host read. From the pins, such an edge is only visible two synchronizer stages later. The stimulus therefore toggles pins and strobes reads in every cycle with random patterns, so reads fall on edge cycles many times. Loopback phases drive `mdm_ctl` directly, which places the edge and the read in the same cycle without pipeline offset. Directed phases drive the RI pin through both directions to show the one-sided flag.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int NUM_LINES = 4;
    localparam int BYTE_W    = 8;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/msr_flag.sv
module msr_flag
    import msr_pkg::*;
#(
    parameter edge_kind_e KIND = EDGE_ANY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rd_clr,
    output logic flag
);
    flag_state_e state_q, state_d;
    logic        prev_q;
    logic        hit;

    generate
        if (KIND == EDGE_FALL) begin : g_fall
            assign hit = prev_q & ~level;
        end else begin : g_any
            assign hit = prev_q ^ level;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= level;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (hit) state_d = FLAG_PENDING;            // SET
            end
            FLAG_PENDING: begin
                if (!hit && rd_clr) state_d = FLAG_IDLE;    // CLEAR
            end
            default: state_d = FLAG_IDLE;
        endcase
        flag = (state_q == FLAG_PENDING);
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !hit) |=> !flag);

    // R3
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && !hit) |=> (flag == $past(flag)));
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cd_n,
    input  logic              ri_n,
    input  logic              dsr_n,
    input  logic              cts_n,
    input  logic              loop_en,
    input  logic [3:0]        mdm_ctl,
    input  logic              reg_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] feat_ctl,
    output logic              msi_irq
);
    localparam int CD_IDX  = 3;
    localparam int RI_IDX  = 2;
    localparam int DSR_IDX = 1;
    localparam int CTS_IDX = 0;

    logic [NUM_LINES-1:0] pin_n;
    logic [NUM_LINES-1:0] pin_sync_n;
    logic [NUM_LINES-1:0] loop_src;
    logic [NUM_LINES-1:0] line_state;
    logic [NUM_LINES-1:0] flags;
    logic                 rd_hit;
    logic                 wr_hit;
    logic [BYTE_W-1:0]    feat_q;

    assign pin_n = {cd_n, ri_n, dsr_n, cts_n};

    genvar gi;
    generate
        for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
            msr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (pin_n[gi]),
                .q     (pin_sync_n[gi])
            );
            msr_flag #(.KIND(gi == RI_IDX ? EDGE_FALL : EDGE_ANY)) u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .level  (line_state[gi]),
                .rd_clr (rd_hit),
                .flag   (flags[gi])
            );
        end
    endgenerate

    // loopback wiring: CD<-OP2, RI<-OP1, DSR<-DTR, CTS<-RTS
    assign loop_src[CD_IDX]  = mdm_ctl[3];
    assign loop_src[RI_IDX]  = mdm_ctl[2];
    assign loop_src[DSR_IDX] = mdm_ctl[0];
    assign loop_src[CTS_IDX] = mdm_ctl[1];

    assign line_state = loop_en ? loop_src : ~pin_sync_n;

    assign rd_hit = rd_stb & reg_sel;
    assign wr_hit = wr_stb & reg_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      feat_q <= '0;
        else if (wr_hit) feat_q <= wr_data;
    end

    assign rd_data  = {line_state, flags};
    assign feat_ctl = feat_q;
    assign msi_irq  = |flags;

    // R9
    feat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (feat_ctl == $past(wr_data)));

    // R10
    feat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(feat_ctl));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_irq |-> (rd_data[3:0] == 4'h0));

    // R4
    ri_rise_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hit && !rd_data[2] && !$past(line_state[RI_IDX]) && line_state[RI_IDX])
        |=> !rd_data[2]);
endmodule

// File: tb/uart_modem_status_tb.sv
module uart_modem_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cd_n = 1'b1, ri_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1;
    logic       loop_en = 1'b0;
    logic [3:0] mdm_ctl = 4'h0;
    logic       reg_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, feat_ctl;
    logic       msi_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    uart_modem_status dut_i (
        .clk(clk), .rst_n(rst_n), .cd_n(cd_n), .ri_n(ri_n), .dsr_n(dsr_n),
        .cts_n(cts_n), .loop_en(loop_en), .mdm_ctl(mdm_ctl), .reg_sel(reg_sel),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
        .feat_ctl(feat_ctl), .msi_irq(msi_irq)
    );

    // reference model state (index 3=CD 2=RI 1=DSR 0=CTS)
    bit m_s1 [4];
    bit m_s2 [4];
    bit m_prev [4];
    bit m_flag [4];
    bit [7:0] m_feat;

    function automatic bit ref_state(int i);
        int lmap [4] = '{1, 0, 2, 3}; // CTS<-RTS, DSR<-DTR, RI<-OP1, CD<-OP2
        if (loop_en) return mdm_ctl[lmap[i]];
        return !m_s2[i];
    endfunction

    function automatic bit [7:0] ref_byte();
        bit [7:0] b;
        for (int i = 0; i < 4; i++) begin
            b[4+i] = ref_state(i);
            b[i]   = m_flag[i];
        end
        return b;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_s1[i] = 1; m_s2[i] = 1; m_prev[i] = 0; m_flag[i] = 0;
        end
        m_feat = 8'h00;
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            bit cur [4];
            bit pins [4];
            bit rd;
            pins = '{cts_n, dsr_n, ri_n, cd_n};
            rd = rd_stb && reg_sel;
            for (int i = 0; i < 4; i++) cur[i] = ref_state(i);
            for (int i = 0; i < 4; i++) begin
                bit ev;
                ev = (i == 2) ? (m_prev[i] && !cur[i]) : (m_prev[i] != cur[i]);
                if (ev) m_flag[i] = 1;
                else if (rd) m_flag[i] = 0;
                m_prev[i] = cur[i];
                m_s2[i] = m_s1[i];
                m_s1[i] = pins[i];
            end
            if (wr_stb && reg_sel) m_feat = wr_data;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            bit [7:0] e;
            e = ref_byte();
            chk(loop_en ? "R2 line state" : "R1 line state", {4'h0, rd_data[7:4]}, {4'h0, e[7:4]});
            chk("R3 R4 R5 R6 R10 flags", {4'h0, rd_data[3:0]}, {4'h0, e[3:0]});
            chk("R7 irq", {7'h0, msi_irq}, {7'h0, (e[3:0] != 0)});
            chk("R9 R10 feat", feat_ctl, m_feat);
        end
        if (cyc > 200000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic host_read();
        reg_sel = 1; rd_stb = 1; step(); rd_stb = 0; reg_sel = 0;
    endtask

    initial begin
        model_reset();
        step(3);
        rst_n = 1;
        step();
        // R8 reset state
        chk("R8 reset byte", rd_data, 8'h00);
        chk("R8 reset feat", feat_ctl, 8'h00);
        // R3 CD falls -> flag
        cd_n = 0; step(4);
        chk("R3 cd flag", rd_data & 8'h88, 8'h88);
        host_read(); step();
        chk("R5 cleared", rd_data & 8'h0F, 8'h00);
        // R4 RI pin low (bit6 rises): no flag; then pin high: flag
        ri_n = 0; step(4);
        chk("R4 ri rise ignored", rd_data & 8'h44, 8'h40);
        ri_n = 1; step(4);
        chk("R4 ri trailing edge", rd_data & 8'h44, 8'h04);
        // R10 read without select keeps flags
        rd_stb = 1; step(); rd_stb = 0; step();
        chk("R10 unselected read", rd_data & 8'h0F, 8'h04);
        host_read();
        // R6 edge lands with read: DSR pin falls, read at edge cycle
        dsr_n = 0; step(2);
        host_read(); step();
        chk("R6 coincident edge", rd_data & 8'h02, 8'h02);
        host_read();
        // R9 writes
        reg_sel = 1; wr_stb = 1; wr_data = 8'hA5; step(); wr_stb = 0; reg_sel = 0;
        step();
        chk("R9 write", feat_ctl, 8'hA5);
        wr_stb = 1; wr_data = 8'h3C; step(); wr_stb = 0; step();
        chk("R10 unselected write", feat_ctl, 8'hA5);
        // R2 loopback with edges on reads
        loop_en = 1;
        for (int k = 0; k < 400; k++) begin
            mdm_ctl = 4'($urandom());
            reg_sel = 1'($urandom()); rd_stb = 1'($urandom());
            step();
        end
        rd_stb = 0; reg_sel = 0; loop_en = 0;
        // random normal mode
        for (int k = 0; k < 2000; k++) begin
            if (($urandom() & 3) == 0) {cd_n, ri_n, dsr_n, cts_n} = 4'($urandom());
            reg_sel = 1'($urandom()); rd_stb = 1'($urandom());
            wr_stb = (($urandom() & 7) == 0); wr_data = 8'($urandom());
            if (k % 500 == 250) loop_en = ~loop_en;
            step();
        end
        step(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule